// File: doc/BRIEF.md
# SDRAM Command Decoder and Rule Checker

This block watches the control and address pins of a four-bank single-data-rate SDRAM and names, every clock, the command being issued. It keeps its own model of which banks hold an open row, whether a data burst is running (and whether that burst will close its bank on its own), how long a bank closed that way must rest, and whether a mode-register write is still settling. Any command that breaks the issue rules raises a flag on a seven-bit violation vector in the same cycle the command appears.

It also produces the two data-mask views of the mask pin: a write-data mask that applies in the very cycle the pin is sampled, and a read-output high-impedance enable that follows the pin two cycles later. The burst length is a configuration input, so one instance can follow a controller whose burst setting changes.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: With clock enable high in the previous and the current cycle and chip select low, the active-low triple (row strobe, column strobe, write enable) decodes as 000 mode set (code 2), 001 refresh (3), 011 activate (5), 101 read (6), 100 write (7), 110 burst stop (8), 010 precharge (9), 111 no operation (0); chip select high gives deselect (1). Clock enable falling from high to low with the refresh pattern and chip select low gives self-refresh entry (4); every other cycle without clock enable high in both cycles gives suspend (10).
- R2: For activate, read, write and single-bank precharge, `bank_sel` is one-hot with bank bit index = {ba[0], ba[1]} (ba 00 bit 0, 10 bit 1, 01 bit 2, 11 bit 3); precharge with `a10` high gives 4'hF and closes every bank; all other commands give 0.
- R3: A mode set while any bank is open sets `viol[0]`.
- R4: After an accepted mode set, any command other than no operation, deselect or suspend in either of the next two cycles sets `viol[1]`.
- R5: Refresh or self-refresh entry while any bank is open sets `viol[2]`.
- R6: A read or write to a closed bank sets `viol[3]`; an activate to an open bank sets `viol[4]`.
- R7: A read or write with `a10` high starts an auto-closing burst of 1, 2, 4 or 8 cycles (`blen` 0..3, counting the command cycle); a read or write issued while such a burst still has cycles left sets `viol[5]`, and one issued in the first cycle after it is allowed.
- R8: When an auto-closing burst ends, its bank is closed and an activate to it sets `viol[6]` for TRP cycles, starting the cycle after the last burst cycle.
- R9: An accepted burst stop ends the running burst at once; if it was auto-closing, the bank closes and its TRP rest starts from the next cycle.
- R10: A command that raises any violation bit leaves bank, burst and mode-set tracking state unchanged.
- R11: `wr_mask` equals `dqm` in the same cycle.
- R12: `rd_hiz` equals the value `dqm` had two cycles earlier.
- R13: After reset all banks are closed, no burst or mode-set window is active and `rd_hiz` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| dqm | input | 1 | Data mask pin |
| ba | input | 2 | Bank address |
| a10 | input | 1 | Address bit 10 (all-bank / auto-close select) |
| blen | input | 2 | Burst length code: 0..3 for 1, 2, 4, 8 |
| cmd | output | 4 | Decoded command code (R1) |
| bank_sel | output | 4 | Banks addressed by the command |
| viol | output | 7 | Rule violation flags |
| wr_mask | output | 1 | Write-data mask, this cycle |
| rd_hiz | output | 1 | Read-output high-impedance enable |

## Verification
The command code, bank selection, violation flags and write mask are due in the same cycle as the pins that cause them, computed from pins and state registered at earlier edges; a command's effect on tracking state first shows in the flags one cycle later, and the read high-impedance enable two cycles later. The bench drives pins just after a rising edge, compares every output at the following falling edge against a behavioural model, and only then advances the model as the design's registers advance at the next rising edge. Directed sequences place commands at exact offsets from a mode set, an auto-closing burst end and a burst stop, and a long random run covers mixed patterns.

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor #(
  parameter int TRP = 3,
  parameter int MRD = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cke,
  input  logic       cs_n,
  input  logic       ras_n,
  input  logic       cas_n,
  input  logic       we_n,
  input  logic       dqm,
  input  logic [1:0] ba,
  input  logic       a10,
  input  logic [1:0] blen,
  output logic [3:0] cmd,
  output logic [3:0] bank_sel,
  output logic [6:0] viol,
  output logic       wr_mask,
  output logic       rd_hiz
);
  localparam int TW = $clog2(TRP + 1);
  localparam int MW = $clog2(MRD + 1);
  localparam logic [3:0] C_NOP = 4'd0, C_DESEL = 4'd1, C_MRS = 4'd2, C_REF = 4'd3,
                         C_SREF = 4'd4, C_ACT = 4'd5, C_RD = 4'd6, C_WR = 4'd7,
                         C_BST = 4'd8, C_PRE = 4'd9, C_SUSP = 4'd10;

  logic          cke_q;
  logic [3:0]    open_q, open_n;
  logic [TW-1:0] trp_q [4];
  logic [2:0]    left_q;
  logic [1:0]    bbank_q;
  logic          bap_q;
  logic [MW-1:0] mrs_q;
  logic          dqm_d1;

  wire [1:0] idx = {ba[0], ba[1]};
  wire [2:0] rcw = {ras_n, cas_n, we_n};

  always_comb begin
    cmd = C_SUSP;
    if (cke_q && cke) begin
      if (cs_n) cmd = C_DESEL;
      else begin
        case (rcw)
          3'b000:  cmd = C_MRS;
          3'b001:  cmd = C_REF;
          3'b011:  cmd = C_ACT;
          3'b101:  cmd = C_RD;
          3'b100:  cmd = C_WR;
          3'b110:  cmd = C_BST;
          3'b010:  cmd = C_PRE;
          default: cmd = C_NOP;
        endcase
      end
    end else if (cke_q && !cs_n && rcw == 3'b001) begin
      cmd = C_SREF;
    end
  end

  wire rdwr   = (cmd == C_RD) || (cmd == C_WR);
  wire is_cmd = !(cmd == C_NOP || cmd == C_DESEL || cmd == C_SUSP);
  wire any_open = |open_q;
  wire bst_on = left_q != 3'd0;

  assign bank_sel = (cmd == C_PRE && a10) ? 4'hF :
                    (cmd == C_ACT || rdwr || cmd == C_PRE) ? (4'd1 << idx) : 4'd0;

  assign viol[0] = (cmd == C_MRS) && any_open;
  assign viol[1] = is_cmd && (mrs_q != '0);
  assign viol[2] = (cmd == C_REF || cmd == C_SREF) && any_open;
  assign viol[3] = rdwr && !open_q[idx];
  assign viol[4] = (cmd == C_ACT) && open_q[idx];
  assign viol[5] = rdwr && bst_on && bap_q;
  assign viol[6] = (cmd == C_ACT) && (trp_q[idx] != '0);

  wire ok     = viol == 7'd0;
  wire ap_end = bst_on && bap_q && (left_q == 3'd1 || (cmd == C_BST && ok));
  wire ap_now = ok && rdwr && a10 && (blen == 2'd0);
  wire [2:0] blen_m1 = 3'((4'd1 << blen) - 4'd1);

  assign wr_mask = dqm;

  always_comb begin
    open_n = open_q;
    if (ap_end) open_n[bbank_q] = 1'b0;
    if (ok) begin
      if (cmd == C_ACT) open_n[idx] = 1'b1;
      if (cmd == C_PRE) begin
        if (a10) open_n = 4'd0;
        else     open_n[idx] = 1'b0;
      end
      if (ap_now) open_n[idx] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_q   <= 1'b1;
      open_q  <= 4'd0;
      left_q  <= 3'd0;
      bbank_q <= 2'd0;
      bap_q   <= 1'b0;
      mrs_q   <= '0;
      dqm_d1  <= 1'b0;
      rd_hiz  <= 1'b0;
      for (int b = 0; b < 4; b++) trp_q[b] <= '0;
    end else begin
      cke_q  <= cke;
      open_q <= open_n;
      dqm_d1 <= dqm;
      rd_hiz <= dqm_d1;
      for (int b = 0; b < 4; b++) begin
        if ((ap_end && bbank_q == 2'(b)) || (ap_now && idx == 2'(b)))
          trp_q[b] <= TW'(TRP);
        else if (trp_q[b] != '0)
          trp_q[b] <= trp_q[b] - 1'b1;
      end
      if (ok && rdwr) begin
        left_q  <= blen_m1;
        bbank_q <= idx;
        bap_q   <= a10;
      end else if (ok && cmd == C_BST) begin
        left_q <= 3'd0;
      end else if (bst_on) begin
        left_q <= left_q - 3'd1;
      end
      if (ok && cmd == C_MRS)  mrs_q <= MW'(MRD);
      else if (mrs_q != '0)    mrs_q <= mrs_q - 1'b1;
    end
  end

  a_r2_sel_shape: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_sel) || bank_sel == 4'hF);

  a_r2_preall_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_PRE && a10 && ok) |=> (open_q == 4'd0));

  a_r4_mrs_window: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_MRS && ok) |=> (!is_cmd || viol[1]));

  a_r6_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_ACT && ok) |=> open_q[$past(idx)]);

  a_r7_ap_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && rdwr && a10 && blen != 2'd0) |=> (!rdwr || viol[5]));

  a_r10_illegal_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!ok && !bst_on) |=> $stable(open_q));

  a_r12_rd_latency: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rst_n, 2)) |-> (rd_hiz == $past(dqm, 2)));
endmodule

// File: tb/sdram_cmd_monitor_bench.sv
module sdram_cmd_monitor_bench;
  localparam int TRP = 3;
  localparam int C_NOP = 0, C_DESEL = 1, C_MRS = 2, C_REF = 3, C_SREF = 4, C_ACT = 5,
                 C_RD = 6, C_WR = 7, C_BST = 8, C_PRE = 9, C_SUSP = 10;
  localparam logic [2:0] P_MRS = 3'b000, P_REF = 3'b001, P_ACT = 3'b011, P_RD = 3'b101,
                         P_WR = 3'b100, P_BST = 3'b110, P_PRE = 3'b010, P_NOP = 3'b111;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic dqm = 1'b0, a10 = 1'b0;
  logic [1:0] ba = 2'd0, blen = 2'd0;
  logic [3:0] cmd, bank_sel;
  logic [6:0] viol;
  logic wr_mask, rd_hiz;

  sdram_cmd_monitor #(.TRP(TRP), .MRD(2)) u_sdram_cmd_monitor (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .dqm(dqm), .ba(ba), .a10(a10), .blen(blen), .cmd(cmd),
    .bank_sel(bank_sel), .viol(viol), .wr_mask(wr_mask), .rd_hiz(rd_hiz));

  int checks = 0, fails = 0;
  bit m_open [4];
  int m_trp [4];
  int m_left = 0, m_bank = 0, m_mrs = 0;
  bit m_ap = 0, m_cke_prev = 1;
  bit dq_hist [$];
  bit d_cur = 0;
  logic [6:0] last_viol;
  logic [3:0] last_cmd;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int bidx(logic [1:0] b);
    if (b == 2'b01) return 2;
    if (b == 2'b10) return 1;
    return int'(b);
  endfunction

  function automatic int exp_cmd();
    if (m_cke_prev && cke) begin
      if (cs_n) return C_DESEL;
      case ({ras_n, cas_n, we_n})
        P_MRS: return C_MRS;
        P_REF: return C_REF;
        P_ACT: return C_ACT;
        P_RD:  return C_RD;
        P_WR:  return C_WR;
        P_BST: return C_BST;
        P_PRE: return C_PRE;
        default: return C_NOP;
      endcase
    end
    if (m_cke_prev && !cs_n && {ras_n, cas_n, we_n} == P_REF) return C_SREF;
    return C_SUSP;
  endfunction

  task automatic step();
    int ec, es, ix, len, ap_end;
    bit anyo, rw, iscmd, ok;
    logic [6:0] ev;
    ix = bidx(ba);
    anyo = m_open[0] | m_open[1] | m_open[2] | m_open[3];
    ec = exp_cmd();
    rw = (ec == C_RD) || (ec == C_WR);
    iscmd = !(ec == C_NOP || ec == C_DESEL || ec == C_SUSP);
    if (ec == C_PRE && a10) es = 15;
    else if (ec == C_ACT || rw || ec == C_PRE) es = 1 << ix;
    else es = 0;
    ev[0] = (ec == C_MRS) && anyo;
    ev[1] = iscmd && (m_mrs > 0);
    ev[2] = (ec == C_REF || ec == C_SREF) && anyo;
    ev[3] = rw && !m_open[ix];
    ev[4] = (ec == C_ACT) && m_open[ix];
    ev[5] = rw && (m_left > 0) && m_ap;
    ev[6] = (ec == C_ACT) && (m_trp[ix] > 0);
    chk("R1 cmd", int'(cmd), ec);
    chk("R2 bank_sel", int'(bank_sel), es);
    chk("R3 viol[0]", int'(viol[0]), int'(ev[0]));
    chk("R4 viol[1]", int'(viol[1]), int'(ev[1]));
    chk("R5 viol[2]", int'(viol[2]), int'(ev[2]));
    chk("R6 viol[3]", int'(viol[3]), int'(ev[3]));
    chk("R6 viol[4]", int'(viol[4]), int'(ev[4]));
    chk("R7 viol[5]", int'(viol[5]), int'(ev[5]));
    chk("R8 viol[6]", int'(viol[6]), int'(ev[6]));
    chk("R11 wr_mask", int'(wr_mask), int'(dqm));
    chk("R12 rd_hiz", int'(rd_hiz), dq_hist.size() >= 2 ? int'(dq_hist[dq_hist.size()-2]) : 0);
    last_viol = viol;
    last_cmd = cmd;
    ok = (ev == 7'd0);
    ap_end = -1;
    if (m_left > 0 && m_ap && (m_left == 1 || (ec == C_BST && ok))) ap_end = m_bank;
    for (int b = 0; b < 4; b++) if (m_trp[b] > 0) m_trp[b]--;
    if (ap_end >= 0) begin m_open[ap_end] = 0; m_trp[ap_end] = TRP; end
    if (ok && rw) begin
      len = 1 << blen;
      if (a10 && len == 1) begin m_open[ix] = 0; m_trp[ix] = TRP; m_left = 0; end
      else begin m_left = len - 1; m_bank = ix; m_ap = a10; end
    end else if (ok && ec == C_BST) m_left = 0;
    else if (m_left > 0) m_left--;
    if (ok && ec == C_ACT) m_open[ix] = 1;
    if (ok && ec == C_PRE) begin
      if (a10) for (int b = 0; b < 4; b++) m_open[b] = 0;
      else m_open[ix] = 0;
    end
    if (ok && ec == C_MRS) m_mrs = 2;
    else if (m_mrs > 0) m_mrs--;
    m_cke_prev = cke;
    dq_hist.push_back(dqm);
  endtask

  task automatic cyc(logic k, logic cs, logic [2:0] rcw, logic [1:0] b, logic a, logic d);
    cke = k; cs_n = cs; {ras_n, cas_n, we_n} = rcw; ba = b; a10 = a; dqm = d;
    @(negedge clk);
    step();
    @(posedge clk);
    #1;
  endtask

  task automatic op(logic [2:0] rcw, logic [1:0] b, logic a);
    cyc(1'b1, 1'b0, rcw, b, a, d_cur);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int b = 0; b < 4; b++) begin m_open[b] = 0; m_trp[b] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    op(P_NOP, 0, 0);
    chk("R13 reset flags", int'(last_viol), 0);
    chk("R13 reset rd_hiz", int'(rd_hiz), 0);
    op(P_RD, 0, 0);
    chk("R13 banks closed after reset", int'(last_viol[3]), 1);
    // mode set window
    op(P_MRS, 0, 0);
    op(P_NOP, 0, 0);
    op(P_ACT, 0, 0);
    chk("R4 command in window flagged", int'(last_viol[1]), 1);
    op(P_ACT, 0, 0);
    chk("R4 window over, R10 flagged act did not open", int'(last_viol), 0);
    op(P_ACT, 0, 0);
    chk("R6 activate open bank", int'(last_viol[4]), 1);
    op(P_MRS, 0, 0);
    chk("R3 mode set with open bank", int'(last_viol[0]), 1);
    op(P_ACT, 2'b11, 0);
    chk("R10 rejected mode set opens no window", int'(last_viol), 0);
    op(P_REF, 0, 0);
    chk("R5 refresh with open bank", int'(last_viol[2]), 1);
    cyc(1'b0, 1'b0, P_REF, 0, 0, 0);
    chk("R1 self refresh code", int'(last_cmd), C_SREF);
    chk("R5 self refresh with open bank", int'(last_viol[2]), 1);
    op(P_NOP, 0, 0);
    chk("R1 suspend after cke low", int'(last_cmd), C_SUSP);
    op(P_PRE, 2'b01, 1);
    op(P_REF, 0, 0);
    chk("R5 refresh legal when all closed", int'(last_viol), 0);
    // auto-closing burst of 4
    op(P_ACT, 0, 0);
    op(P_ACT, 2'b10, 0);
    blen = 2'd2;
    op(P_RD, 2'b10, 1);
    op(P_RD, 0, 0);
    chk("R7 read during auto-close burst", int'(last_viol[5]), 1);
    op(P_NOP, 0, 0);
    op(P_NOP, 0, 0);
    op(P_RD, 0, 0);
    chk("R7 read after burst end", int'(last_viol), 0);
    op(P_ACT, 2'b10, 0);
    chk("R8 activate inside rest", int'(last_viol[6]), 1);
    op(P_NOP, 0, 0);
    op(P_ACT, 2'b10, 0);
    chk("R8 activate after rest", int'(last_viol), 0);
    // burst stop on an auto-closing burst of 8
    op(P_ACT, 2'b01, 0);
    blen = 2'd3;
    op(P_WR, 2'b01, 1);
    op(P_NOP, 0, 0);
    op(P_BST, 0, 0);
    op(P_WR, 0, 0);
    chk("R9 write after burst stop", int'(last_viol), 0);
    op(P_ACT, 2'b01, 0);
    chk("R9 stopped bank closed and resting", int'(last_viol[6]), 1);
    // single-cycle auto-close
    blen = 2'd0;
    op(P_RD, 0, 1);
    op(P_RD, 0, 0);
    chk("R7 single-cycle burst closes bank", int'(last_viol[3]), 1);
    // mask pattern
    foreach (dq_hist[i]) if (i < 0) d_cur = 0;
    for (int i = 0; i < 8; i++) begin
      d_cur = (8'b10011010 >> i) & 1;
      op(P_NOP, 0, 0);
    end
    d_cur = 0;
    // random phase
    for (int i = 0; i < 5000; i++) begin
      logic k, cs;
      logic [2:0] r;
      k = ($urandom % 16) != 0;
      cs = ($urandom % 8) == 0;
      r = 3'($urandom);
      if (($urandom % 4) == 0) r = P_NOP;
      if (($urandom % 32) == 0) blen = 2'($urandom);
      cyc(k, cs, r, 2'($urandom), 1'(($urandom % 3) == 0), 1'($urandom));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule